// File: doc/BRIEF.md
# Interrupt-on-change controller

This block watches two 8-bit input ports, already synchronized to the local clock, and raises an interrupt when an enabled pin departs from its reference. Each pin picks its own reference. It can be the level the pin had on the previous clock, so the interrupt means "this pin changed". It can also be a programmed default bit, so the interrupt means "this pin is not at its expected level".

When an interrupt is taken, the block latches two things for that port. A flag vector names the pins that caused it. A capture vector holds the pin levels at that moment. Both stay frozen until software reads the port's capture register or its live port register, and that read clears the interrupt. A default-mismatch condition that is still present after the clear raises the interrupt again on the next clock.

Each port has one interrupt output. The line can be driven push-pull, active high or active low, or as an open-drain pull-down. A mirror control ORs both ports' interrupts onto both lines. Register access uses a write strobe, a read strobe and a 4-bit address. Read data is combinational.

Top module: `ioc_ctrl`

## Requirements
- R1: After reset, the flags and capture of both ports read 0 and no interrupt is active. The enable, mode and default registers read 0.
- R2: A pin whose enable bit is 0 never raises an interrupt, whatever its level does.
- R3: An enabled pin in change mode (mode bit 0) that differs from its level on the previous clock sets the port's interrupt. The interrupt is visible after the clock edge that samples the new level. The same edge sets that pin's flag bit.
- R4: An enabled pin in default mode (mode bit 1) whose level is the opposite of its default bit raises the port's interrupt and sets its flag bit.
- R5: Writes to the flag, capture and port addresses change nothing.
- R6: The capture register holds the pin levels sampled on the edge that raised the interrupt. Capture and flags stay unchanged while the interrupt is pending, even if the pins change.
- R7: A read strobe on the port's capture or port address clears the interrupt and its flags at the next edge. Reads of any other address do not clear it.
- R8: If a default-mode mismatch is still present when the interrupt is cleared, the interrupt is raised again on the following edge.
- R9: Interrupt line drive depends on the open-drain control.
  - Push-pull (open-drain control 0): the enable output is always 1. The line level is the polarity bit when active and its inverse when idle.
  - Open-drain (open-drain control 1): the line level is always 0 and the enable output equals the active state.
- R10: With mirror set, each line is active when either port's interrupt is pending. With mirror clear, each line follows only its own port.
- R11: Address map. Bit 0 selects the port (0 = A, 1 = B). Bits 3:1 select the register: 0 enable, 1 mode, 2 default, 3 flags, 4 capture, 5 live port value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_a | input | 8 | Synchronized levels of port A |
| pin_b | input | 8 | Synchronized levels of port B |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clear side effect) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| cfg_mirror | input | 1 | OR both ports onto both lines |
| cfg_odr | input | 1 | 1 = open-drain lines |
| cfg_pol | input | 1 | Push-pull active level |
| irq_a_out | output | 1 | Line A level |
| irq_a_oe | output | 1 | Line A drive enable |
| irq_b_out | output | 1 | Line B level |
| irq_b_oe | output | 1 | Line B drive enable |

## Verification
The hardest case to reach is re-assertion after a clear. It needs the pin to hold a default mismatch through the clearing read, and it must be told apart from a fresh change-mode event. The stimulus puts port B in default mode and holds the mismatching level across the read. It checks the line idle on exactly the cycle after the clearing edge and active on the next. It then removes the mismatch and confirms that a second clear leaves the line idle. Frozen capture is reached by changing the pins again while an interrupt is pending.

// File: rtl/ioc_pkg.sv
// Package: register selector codes shared by the interrupt-on-change block.
// Assumes a 3-bit selector taken from address bits 3:1.
package ioc_pkg;
    typedef enum logic [2:0] {
        SEL_EN   = 3'd0,
        SEL_MODE = 3'd1,
        SEL_DFLT = 3'd2,
        SEL_FLAG = 3'd3,
        SEL_CAP  = 3'd4,
        SEL_PORT = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/ioc_port.sv
// One port's interrupt-on-change state: config registers, reference,
// pending bit, flags and capture. Assumes pin is already synchronous.
module ioc_port
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic         hit,
    input  reg_sel_e     sel,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         pend,
    output logic [W-1:0] flags,
    output logic [W-1:0] cap
);
    logic [W-1:0] en_q, mode_q, dflt_q, prev_q, mism;
    logic         clr;

    // Per-pin mismatch against the chosen reference, gated by enable.
    always_comb mism = en_q & ((mode_q & (pin ^ dflt_q)) | (~mode_q & (pin ^ prev_q)));

    // Clearing read: capture or live port address of this port.
    always_comb clr = hit && rd_en && (sel == SEL_CAP || sel == SEL_PORT);

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            dflt_q <= '0;
        end else if (wr_en && hit) begin
            case (sel)
                SEL_EN:   en_q   <= wdata;
                SEL_MODE: mode_q <= wdata;
                SEL_DFLT: dflt_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Pending, flags and capture: latch when idle, hold until a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            flags <= '0;
            cap   <= '0;
        end else if (!pend) begin
            if (|mism) begin
                pend  <= 1'b1;
                flags <= mism;
                cap   <= pin;
            end
        end else if (clr) begin
            pend  <= 1'b0;
            flags <= '0;
        end
    end

    // Previous-value reference follows the pins unless an interrupt holds it.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else if (!pend || clr) prev_q <= pin;
    end

    // Readback multiplexer.
    always_comb begin
        case (sel)
            SEL_EN:   rdata = en_q;
            SEL_MODE: rdata = mode_q;
            SEL_DFLT: rdata = dflt_q;
            SEL_FLAG: rdata = flags;
            SEL_CAP:  rdata = cap;
            SEL_PORT: rdata = pin;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ioc_drive.sv
// Interrupt line driver: push-pull with selectable level or open-drain.
// Assumes a pad that honours oe; out is the level when oe is 1.
module ioc_drive (
    input  logic act,
    input  logic odr,
    input  logic pol,
    output logic out,
    output logic oe
);
    // Choose level and enable from drive type.
    always_comb begin
        if (odr) begin
            out = 1'b0;
            oe  = act;
        end else begin
            out = act ? pol : ~pol;
            oe  = 1'b1;
        end
    end
endmodule

// File: rtl/ioc_ctrl.sv
// Top: two ports of interrupt-on-change logic, address decode, mirror
// combining and line drivers. Assumes synchronous pins and strobes.
module ioc_ctrl
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_a,
    input  logic [W-1:0] pin_b,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [3:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         cfg_mirror,
    input  logic         cfg_odr,
    input  logic         cfg_pol,
    output logic         irq_a_out,
    output logic         irq_a_oe,
    output logic         irq_b_out,
    output logic         irq_b_oe
);
    localparam int NPORT = 2;

    logic [NPORT-1:0][W-1:0] pins, port_rd, flags_all, cap_all;
    logic [NPORT-1:0]        pend, line_act, line_out, line_oe;
    reg_sel_e                sel;

    // Address decode into register selector.
    always_comb sel = reg_sel_e'(addr[3:1]);

    // Pack port inputs.
    always_comb begin
        pins[0] = pin_a;
        pins[1] = pin_b;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        ioc_port #(.W(W)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pins[g]),
            .hit   (addr[0] == 1'(g)),
            .sel   (sel),
            .wr_en (wr_en),
            .rd_en (rd_en),
            .wdata (wdata),
            .rdata (port_rd[g]),
            .pend  (pend[g]),
            .flags (flags_all[g]),
            .cap   (cap_all[g])
        );

        // Mirror combines all ports onto each line.
        always_comb line_act[g] = cfg_mirror ? (|pend) : pend[g];

        ioc_drive u_drive (
            .act (line_act[g]),
            .odr (cfg_odr),
            .pol (cfg_pol),
            .out (line_out[g]),
            .oe  (line_oe[g])
        );
    end

    // Readback from the addressed port.
    always_comb rdata = port_rd[addr[0]];

    // Output mapping.
    always_comb begin
        irq_a_out = line_out[0];
        irq_a_oe  = line_oe[0];
        irq_b_out = line_out[1];
        irq_b_oe  = line_oe[1];
    end
endmodule

// File: rtl/ioc_ctrl_chk.sv
// Checker for ioc_ctrl, attached with bind; observes pending state,
// flags, capture and the line pins.
module ioc_ctrl_chk #(
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [3:0]          addr,
    input logic                cfg_mirror,
    input logic                cfg_odr,
    input logic [1:0]          pend,
    input logic [1:0][W-1:0]   flags_all,
    input logic [1:0][W-1:0]   cap_all,
    input logic                irq_a_out,
    input logic                irq_a_oe,
    input logic                irq_b_out,
    input logic                irq_b_oe
);
    assert_pend_has_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] |-> flags_all[0] != '0);

    assert_flags_move_only_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flags_all[1]) |-> ($rose(pend[1]) || $fell(pend[1])));

    assert_cap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && $past(pend[0])) |-> $stable(cap_all[0]));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && rd_en && addr == 4'h8) |=> !pend[0]);

    assert_od_level_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_odr |-> (!irq_a_out && !irq_b_out));

    assert_pp_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_odr |-> (irq_a_oe && irq_b_oe));

    assert_mirror_lines_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mirror |-> (irq_a_out == irq_b_out && irq_a_oe == irq_b_oe));
endmodule

bind ioc_ctrl ioc_ctrl_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .addr       (addr),
    .cfg_mirror (cfg_mirror),
    .cfg_odr    (cfg_odr),
    .pend       (pend),
    .flags_all  (flags_all),
    .cap_all    (cap_all),
    .irq_a_out  (irq_a_out),
    .irq_a_oe   (irq_a_oe),
    .irq_b_out  (irq_b_out),
    .irq_b_oe   (irq_b_oe)
);

// File: tb/test_ioc_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected items just after a rising
// edge; the monitor pops and compares them at the following falling edge.
module test_ioc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_a = '0, pin_b = '0, wdata = '0, rdata;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic       cfg_mirror = 1'b0, cfg_odr = 1'b0, cfg_pol = 1'b1;
    logic       irq_a_out, irq_a_oe, irq_b_out, irq_b_oe;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        bit         is_irq;
        logic [7:0] val;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    ioc_ctrl i_ioc_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .cfg_mirror(cfg_mirror), .cfg_odr(cfg_odr), .cfg_pol(cfg_pol),
        .irq_a_out(irq_a_out), .irq_a_oe(irq_a_oe),
        .irq_b_out(irq_b_out), .irq_b_oe(irq_b_oe)
    );

    // Monitor: compare every queued item at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            act = it.is_irq ? {4'b0, irq_a_out, irq_a_oe, irq_b_out, irq_b_oe} : rdata;
            checks++;
            if (act !== it.val) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.val);
            end
        end
    end

    // Expected line bits from R9/R10.
    function automatic logic [7:0] exp_irq(bit a, bit b);
        bit ia, ib;
        logic [1:0] la, lb;
        ia = cfg_mirror ? (a | b) : a;
        ib = cfg_mirror ? (a | b) : b;
        la = cfg_odr ? {1'b0, ia} : {(ia ? cfg_pol : ~cfg_pol), 1'b1};
        lb = cfg_odr ? {1'b0, ib} : {(ib ? cfg_pol : ~cfg_pol), 1'b1};
        return {4'b0, la, lb};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_strobe(input logic [3:0] a);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [3:0] a, input logic [7:0] v);
        addr = a;
        q.push_back('{tag, 1'b0, v});
        tick();
    endtask

    task automatic chk_irq(input string tag, input bit a, input bit b);
        q.push_back('{tag, 1'b1, exp_irq(a, b)});
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state (R11 addresses: en A 0, mode B 3, dflt A 4, flag A 6, cap B 9)
        chk_rd("R1 en A", 4'h0, 8'h00);
        chk_rd("R1 mode B", 4'h3, 8'h00);
        chk_rd("R1 dflt A", 4'h4, 8'h00);
        chk_rd("R1 flags A", 4'h6, 8'h00);
        chk_rd("R1 cap B", 4'h9, 8'h00);
        chk_irq("R1 lines idle", 0, 0);
        // R2 disabled pin
        pin_a = 8'h01; tick();
        chk_irq("R2 disabled pin quiet", 0, 0);
        // R3 change mode
        wr(4'h0, 8'hFF);
        pin_a = 8'h81; tick();
        chk_irq("R3 change raises A", 1, 0);
        chk_rd("R3 flags A", 4'h6, 8'h80);
        chk_rd("R6 cap A", 4'h8, 8'h81);
        // R6 frozen while pending
        pin_a = 8'h00; tick();
        chk_rd("R6 flags frozen", 4'h6, 8'h80);
        chk_rd("R6 cap frozen", 4'h8, 8'h81);
        // R7 other read does not clear, capture read clears
        rd_strobe(4'h0);
        chk_irq("R7 enable read keeps irq", 1, 0);
        rd_strobe(4'h8);
        chk_irq("R7 capture read clears", 0, 0);
        chk_rd("R7 flags cleared", 4'h6, 8'h00);
        // R5 read-only addresses
        wr(4'h6, 8'hFF);
        chk_rd("R5 flag write ignored", 4'h6, 8'h00);
        wr(4'h8, 8'h55);
        chk_rd("R5 cap write ignored", 4'h8, 8'h81);
        wr(4'hA, 8'h3C);
        chk_rd("R5 port write ignored", 4'hA, 8'h00);
        chk_irq("R5 no irq from writes", 0, 0);
        // R4 / R8 default mode on port B
        wr(4'h3, 8'h0F);
        wr(4'h5, 8'h00);
        wr(4'h1, 8'h0F);
        chk_irq("R4 match quiet", 0, 0);
        pin_b = 8'h04; tick();
        chk_irq("R4 mismatch raises B", 0, 1);
        chk_rd("R4 flags B", 4'h7, 8'h04);
        chk_rd("R6 cap B", 4'h9, 8'h04);
        rd_strobe(4'hB);
        chk_irq("R8 idle after clear", 0, 0);
        chk_irq("R8 reasserts", 0, 1);
        pin_b = 8'h00;
        rd_strobe(4'h9);
        chk_irq("R8 cleared after mismatch gone", 0, 0);
        chk_irq("R8 stays idle", 0, 0);
        // R10 mirror
        cfg_mirror = 1'b1;
        pin_b = 8'h02; tick();
        chk_irq("R10 mirror both lines", 0, 1);
        // R9 open-drain and active-low
        cfg_odr = 1'b1;
        chk_irq("R9 open-drain active", 0, 1);
        cfg_odr = 1'b0; cfg_pol = 1'b0;
        chk_irq("R9 active-low active", 0, 1);
        pin_b = 8'h00;
        rd_strobe(4'h9);
        chk_irq("R9 active-low idle", 0, 0);
        cfg_mirror = 1'b0;
        // R11 map: default A write, B untouched
        wr(4'h4, 8'hA5);
        chk_rd("R11 dflt A", 4'h4, 8'hA5);
        chk_rd("R11 dflt B", 4'h5, 8'h00);
        chk_rd("R11 mode A", 4'h2, 8'h00);
        tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule